// File: doc/BRIEF.md
# Embedded Sync Code Frame Decoder

This block sits behind the lane logic of an image sensor receiver whose line and frame timing travels inside the pixel stream itself. There are no horizontal or vertical sync pins. It takes one 12-bit word per accepted beat. It watches for the reserved prefix of one all-ones word followed by two all-zeros words. The word after that prefix is compared against four programmable code values: start of valid line, end of valid line, start of blanking line, and end of blanking line. Only the pixel words that lie between a valid-line start and its end leave the block. They carry a first-of-line marker and a first-of-frame marker.

The sensor sends no frame codes, so frames are rebuilt from line codes. A frame opens at the first valid-line start seen while no frame is open, which is the case after reset and after a frame has closed. A frame closes when the programmed number of valid lines has ended, or early when a blanking line starts inside an open frame. The early close is reported as a height error. Each valid line's pixel count is checked against a programmed width. Single-cycle status pulses report frame start, frame end, and the three error kinds. Typical settings are a width of 2464 words and a height of 2067 lines, where the first line holds embedded frame information.

Both stream sides use valid/ready. A word is taken when `in_valid` and `in_ready` are both high. The output holds one register stage. `in_ready` is high whenever that stage is empty or is being drained in the same cycle. A stalled output therefore stalls the input, and no word is ever lost. While `out_valid` is high and `out_ready` is low, the output word and its markers hold still.

Top module: `sync_frame_decoder`

## Requirements
- R1: A sync sequence is four accepted words: 0xFFF, 0x000, 0x000 and then a code word. None of these four words ever appears at the output.
- R2: The code word is classified by comparing it with `cfg_code_sol`, `cfg_code_eol`, `cfg_code_sil` and `cfg_code_eil`, checked in that priority order. The usual values are 0x800, 0x9D0, 0xAB0 and 0xB60. Changing a port value changes which word is recognised.
- R3: `out_valid` is raised only for words strictly between a valid-line start code and the following valid-line end code. Words on blanking lines and words outside any line are dropped.
- R4: `out_sol` is high on the first output word of every valid line. `out_sof` is high only on the first output word of the first line of a frame.
- R5: `sof_pulse` is high for the one cycle after a valid-line start code is accepted while no frame is open. No frame is open after reset or after an end of frame.
- R6: `eof_pulse` is high for the one cycle after the valid-line end code that completes line number `cfg_frame_height` of the frame.
- R7: A blanking-line start accepted while a frame is open raises `eof_pulse` and `err_height` in the same cycle and closes the frame.
- R8: A valid-line end code whose line held a number of pixel words other than `cfg_line_width` raises `err_len` for one cycle.
- R9: A code word that matches none of the four codes raises `err_code` for one cycle. The four words are dropped, and the line and frame state are left unchanged.
- R10: `in_ready` is low exactly when `out_valid` is high and `out_ready` is low. While stalled, `out_data`, `out_sol` and `out_sof` hold their values.
- R11: After reset `out_valid` and all pulses are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_code_sol | input | 12 | Code word for a valid-line start |
| cfg_code_eol | input | 12 | Code word for a valid-line end |
| cfg_code_sil | input | 12 | Code word for a blanking-line start |
| cfg_code_eil | input | 12 | Code word for a blanking-line end |
| cfg_line_width | input | 16 | Expected pixel words per valid line |
| cfg_frame_height | input | 16 | Valid lines per frame |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can take a word |
| in_data | input | 12 | Input word |
| out_valid | output | 1 | Output pixel present |
| out_ready | input | 1 | Sink takes the output pixel |
| out_data | output | 12 | Output pixel |
| out_sol | output | 1 | First pixel of a line |
| out_sof | output | 1 | First pixel of a frame |
| sof_pulse | output | 1 | Frame started |
| eof_pulse | output | 1 | Frame ended |
| err_len | output | 1 | Line width mismatch |
| err_height | output | 1 | Frame closed before its line count |
| err_code | output | 1 | Unrecognised code word |

## Verification
The two functions that meet in one cycle are the end of a frame and the height error. Both come from the same blanking-line start when a frame stops short. The bench provokes this by sending two valid lines of a three-line frame and then a blanking line. It judges the result by comparing the accumulated counts of both pulses with the counts it expects. Output back-pressure also meets sync detection throughout the run. A pseudo-random `out_ready` stalls the output while code words are arriving, and a scoreboard checks that every pixel and marker arrives once and in order.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
  localparam int PRE_LEN = 3;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_SOL,
    KIND_EOL,
    KIND_SIL,
    KIND_EIL,
    KIND_UNK
  } sync_kind_e;
endpackage

// File: rtl/sfd_sync_detect.sv
module sfd_sync_detect
  import sfd_pkg::*;
#(
  parameter int W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept,
  input  logic [W-1:0]     data,
  input  logic [W-1:0]     cfg_sol,
  input  logic [W-1:0]     cfg_eol,
  input  logic [W-1:0]     cfg_sil,
  input  logic [W-1:0]     cfg_eil,
  output logic             pix_valid,
  output logic [W-1:0]     pix_data,
  output sync_kind_e       kind
);
  localparam int FILL_W = $clog2(PRE_LEN + 1);
  localparam logic [FILL_W-1:0] FULL = FILL_W'(PRE_LEN);

  logic [W-1:0]      dly [PRE_LEN];
  logic [FILL_W-1:0] fill;
  logic              prefix_seen;

  always_comb begin
    prefix_seen = (fill == FULL) && (dly[PRE_LEN-1] == {W{1'b1}});
    for (int i = 0; i < PRE_LEN - 1; i++)
      prefix_seen = prefix_seen && (dly[i] == '0);
  end

  always_comb begin
    kind = KIND_NONE;
    if (accept && prefix_seen) begin
      if (data == cfg_sol)      kind = KIND_SOL;
      else if (data == cfg_eol) kind = KIND_EOL;
      else if (data == cfg_sil) kind = KIND_SIL;
      else if (data == cfg_eil) kind = KIND_EIL;
      else                      kind = KIND_UNK;
    end
  end

  assign pix_valid = accept && (fill == FULL) && !prefix_seen;
  assign pix_data  = dly[PRE_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill <= '0;
      for (int i = 0; i < PRE_LEN; i++) dly[i] <= '0;
    end else if (accept) begin
      if (prefix_seen) begin
        fill <= '0;
      end else begin
        for (int i = PRE_LEN - 1; i > 0; i--) dly[i] <= dly[i-1];
        dly[0] <= data;
        if (fill != FULL) fill <= fill + 1'b1;
      end
    end
  end

  // R1
  code_flushes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (kind != KIND_NONE) |=> !pix_valid);
endmodule

// File: rtl/sfd_frame_tracker.sv
module sfd_frame_tracker
  import sfd_pkg::*;
#(
  parameter int W     = 12,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_valid,
  input  sync_kind_e       kind,
  input  logic [CNT_W-1:0] cfg_line_width,
  input  logic [CNT_W-1:0] cfg_frame_height,
  output logic             emit,
  output logic             emit_sol,
  output logic             emit_sof,
  output logic             sof_pulse,
  output logic             eof_pulse,
  output logic             err_len,
  output logic             err_height,
  output logic             err_code
);
  logic             in_line;
  logic             frame_open;
  logic             sol_pend;
  logic             sof_pend;
  logic [CNT_W-1:0] word_cnt;
  logic [CNT_W-1:0] line_cnt;
  logic [CNT_W-1:0] lines_next;

  assign emit       = pix_valid && in_line;
  assign emit_sol   = sol_pend;
  assign emit_sof   = sof_pend;
  assign lines_next = line_cnt + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_line    <= 1'b0;
      frame_open <= 1'b0;
      sol_pend   <= 1'b0;
      sof_pend   <= 1'b0;
      word_cnt   <= '0;
      line_cnt   <= '0;
      sof_pulse  <= 1'b0;
      eof_pulse  <= 1'b0;
      err_len    <= 1'b0;
      err_height <= 1'b0;
      err_code   <= 1'b0;
    end else begin
      sof_pulse  <= 1'b0;
      eof_pulse  <= 1'b0;
      err_len    <= 1'b0;
      err_height <= 1'b0;
      err_code   <= 1'b0;
      if (emit) begin
        if (word_cnt != {CNT_W{1'b1}}) word_cnt <= word_cnt + 1'b1;
        sol_pend <= 1'b0;
        sof_pend <= 1'b0;
      end
      case (kind)
        KIND_SOL: begin
          in_line  <= 1'b1;
          word_cnt <= '0;
          sol_pend <= 1'b1;
          if (!frame_open) begin
            frame_open <= 1'b1;
            line_cnt   <= '0;
            sof_pend   <= 1'b1;
            sof_pulse  <= 1'b1;
          end
        end
        KIND_EOL: begin
          if (in_line) begin
            in_line  <= 1'b0;
            sol_pend <= 1'b0;
            sof_pend <= 1'b0;
            if (word_cnt != cfg_line_width) err_len <= 1'b1;
            if (lines_next == cfg_frame_height) begin
              eof_pulse  <= 1'b1;
              frame_open <= 1'b0;
              line_cnt   <= '0;
            end else begin
              line_cnt <= lines_next;
            end
          end
        end
        KIND_SIL: begin
          in_line  <= 1'b0;
          sol_pend <= 1'b0;
          sof_pend <= 1'b0;
          if (frame_open) begin
            eof_pulse  <= 1'b1;
            err_height <= 1'b1;
            frame_open <= 1'b0;
            line_cnt   <= '0;
          end
        end
        KIND_EIL: begin
          in_line  <= 1'b0;
          sol_pend <= 1'b0;
          sof_pend <= 1'b0;
        end
        KIND_UNK: err_code <= 1'b1;
        default: ;
      endcase
    end
  end

  // R7
  height_err_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_height |-> (eof_pulse && !frame_open));
  // R6
  eof_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eof_pulse |-> !frame_open);
  // R5
  sof_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_pulse |-> (frame_open && in_line && sof_pend));
  // R4
  sof_marks_sol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && emit_sof) |-> emit_sol);
endmodule

// File: rtl/sfd_out_reg.sv
module sfd_out_reg #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         load_sol,
  input  logic         load_sof,
  input  logic         out_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  output logic         out_sol,
  output logic         out_sof,
  output logic         space
);
  assign space = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_sol   <= 1'b0;
      out_sof   <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= load_data;
      out_sol   <= load_sol;
      out_sof   <= load_sof;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_sol) && $stable(out_sof)));
endmodule

// File: rtl/sync_frame_decoder.sv
module sync_frame_decoder
  import sfd_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] cfg_code_sol,
  input  logic [DATA_W-1:0] cfg_code_eol,
  input  logic [DATA_W-1:0] cfg_code_sil,
  input  logic [DATA_W-1:0] cfg_code_eil,
  input  logic [CNT_W-1:0]  cfg_line_width,
  input  logic [CNT_W-1:0]  cfg_frame_height,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              out_sol,
  output logic              out_sof,
  output logic              sof_pulse,
  output logic              eof_pulse,
  output logic              err_len,
  output logic              err_height,
  output logic              err_code
);
  logic              accept;
  logic              pix_valid;
  logic [DATA_W-1:0] pix_data;
  sync_kind_e        kind;
  logic              emit;
  logic              emit_sol;
  logic              emit_sof;

  assign accept = in_valid && in_ready;

  sfd_sync_detect #(.W(DATA_W)) u_detect (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .data      (in_data),
    .cfg_sol   (cfg_code_sol),
    .cfg_eol   (cfg_code_eol),
    .cfg_sil   (cfg_code_sil),
    .cfg_eil   (cfg_code_eil),
    .pix_valid (pix_valid),
    .pix_data  (pix_data),
    .kind      (kind)
  );

  sfd_frame_tracker #(.W(DATA_W), .CNT_W(CNT_W)) u_track (
    .clk              (clk),
    .rst_n            (rst_n),
    .pix_valid        (pix_valid),
    .kind             (kind),
    .cfg_line_width   (cfg_line_width),
    .cfg_frame_height (cfg_frame_height),
    .emit             (emit),
    .emit_sol         (emit_sol),
    .emit_sof         (emit_sof),
    .sof_pulse        (sof_pulse),
    .eof_pulse        (eof_pulse),
    .err_len          (err_len),
    .err_height       (err_height),
    .err_code         (err_code)
  );

  sfd_out_reg #(.W(DATA_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (emit),
    .load_data (pix_data),
    .load_sol  (emit_sol),
    .load_sof  (emit_sof),
    .out_ready (out_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_sol   (out_sol),
    .out_sof   (out_sof),
    .space     (in_ready)
  );

  // R3
  out_from_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(in_valid && in_ready));
endmodule

// File: tb/sync_frame_decoder_bench.sv
module sync_frame_decoder_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] cfg_code_sol = 12'h800;
  logic [11:0] cfg_code_eol = 12'h9D0;
  logic [11:0] cfg_code_sil = 12'hAB0;
  logic [11:0] cfg_code_eil = 12'hB60;
  logic [15:0] cfg_line_width = 16'd4;
  logic [15:0] cfg_frame_height = 16'd3;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [11:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [11:0] out_data;
  logic        out_sol, out_sof;
  logic        sof_pulse, eof_pulse, err_len, err_height, err_code;

  int errors = 0;
  int checks = 0;
  int n_sof = 0, n_eof = 0, n_len = 0, n_hgt = 0, n_code = 0;
  int e_sof = 0, e_eof = 0, e_len = 0, e_hgt = 0, e_code = 0;
  logic [13:0] exp_q[$];
  logic [11:0] pix_seq = 12'h100;
  logic [7:0]  lfsr = 8'h5A;

  always #10 clk = ~clk;

  sync_frame_decoder u_sync_frame_decoder (
    .clk(clk), .rst_n(rst_n),
    .cfg_code_sol(cfg_code_sol), .cfg_code_eol(cfg_code_eol),
    .cfg_code_sil(cfg_code_sil), .cfg_code_eil(cfg_code_eil),
    .cfg_line_width(cfg_line_width), .cfg_frame_height(cfg_frame_height),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sol(out_sol), .out_sof(out_sof),
    .sof_pulse(sof_pulse), .eof_pulse(eof_pulse),
    .err_len(err_len), .err_height(err_height), .err_code(err_code)
  );

  task automatic check_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor and scoreboard
  always begin
    @(negedge clk);
    out_ready = lfsr[0] | lfsr[1];
    lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    #2;
    if (rst_n) begin
      n_sof  += int'(sof_pulse);
      n_eof  += int'(eof_pulse);
      n_len  += int'(err_len);
      n_hgt  += int'(err_height);
      n_code += int'(err_code);
      if (out_valid && !out_ready) check_eq("R10 in_ready while stalled", int'(in_ready), 0);
      if (out_valid && out_ready) begin
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R3 unexpected word act=%h exp=none", out_data);
        end else begin
          logic [13:0] e;
          e = exp_q.pop_front();
          if ({out_sof, out_sol, out_data} != e) begin
            errors++;
            $display("FAIL R3/R4 word act=%h exp=%h", {out_sof, out_sol, out_data}, e);
          end
        end
      end
    end
  end

  task automatic send(input logic [11:0] w);
    @(negedge clk); #1;
    in_valid = 1'b1;
    in_data  = w;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); #1;
    in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sync(input logic [11:0] code);
    send(12'hFFF); send(12'h000); send(12'h000); send(code);
  endtask

  task automatic vline(input int n, input bit first, input bit bad_code_mid);
    sync(cfg_code_sol);
    for (int i = 0; i < n; i++) begin
      if (bad_code_mid && i == 2) sync(12'h123);
      send(pix_seq);
      exp_q.push_back({(first && i == 0), (i == 0), pix_seq});
      pix_seq++;
    end
    sync(cfg_code_eol);
  endtask

  task automatic iline(input int n);
    sync(cfg_code_sil);
    for (int i = 0; i < n; i++) send(12'h055);
    sync(cfg_code_eil);
  endtask

  task automatic tally(input string tag);
    idle(12);
    check_eq({tag, " R5 sof count"}, n_sof, e_sof);
    check_eq({tag, " R6 eof count"}, n_eof, e_eof);
    check_eq({tag, " R8 len errors"}, n_len, e_len);
    check_eq({tag, " R7 height errors"}, n_hgt, e_hgt);
    check_eq({tag, " R9 code errors"}, n_code, e_code);
    check_eq({tag, " R1 R3 pending words"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog act=running exp=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    check_eq("R11 out_valid", int'(out_valid), 0);
    check_eq("R11 in_ready", int'(in_ready), 1);
    check_eq("R11 pulses", int'(sof_pulse | eof_pulse | err_len | err_height | err_code), 0);
    rst_n = 1'b1;
    idle(2);

    // R3 blanking words are dropped
    iline(5);
    tally("blank");

    // R1 R4 R5 R6 full frame
    vline(4, 1, 0); vline(4, 0, 0); vline(4, 0, 0);
    e_sof++; e_eof++;
    tally("frame1");

    // R7 short frame closed by a blanking line
    iline(2);
    vline(4, 1, 0); vline(4, 0, 0);
    iline(3);
    e_sof++; e_eof++; e_hgt++;
    tally("short");

    // R8 line of wrong width
    vline(4, 1, 0); vline(3, 0, 0); vline(4, 0, 0);
    e_sof++; e_eof++; e_len++;
    tally("width");

    // R9 unknown code inside a line leaves the line intact
    iline(1);
    vline(4, 1, 1); vline(4, 0, 0); vline(4, 0, 0);
    e_sof++; e_eof++; e_code++;
    tally("unknown");

    // R2 programmed codes and height
    idle(1);
    cfg_code_sol = 12'h801;
    cfg_frame_height = 16'd1;
    sync(12'h800);
    e_code++;
    vline(4, 1, 0);
    e_sof++; e_eof++;
    vline(4, 1, 0);
    e_sof++; e_eof++;
    tally("R2 reprogram");

    summary();
    $finish;
  end
endmodule